// File: doc/BRIEF.md
# Exact Least-Recently-Used Way Tracker

This block holds the replacement state for one group of ways in an associative cache. It can serve a single set of a set-associative array, or every entry of a fully associative one. It keeps a complete ranking of the ways, from the one touched longest ago to the one touched most recently. The least recent way is offered at all times as the candidate for eviction.

The cache controller reports each lookup with a strobe, a hit flag and the way that matched. When a miss is later served by writing a line into some way, the controller reports that with a separate fill strobe and way number.

- A hit moves the matching way to the newest end of the ranking.
- A fill moves the written way to the newest end.
- A lookup that misses, with no fill in the same cycle, changes nothing.

Because the ranking after reset is way 0 oldest through the last way newest, empty ways are handed out in ascending order.

Top module: `lru_tracker`

## Requirements
- R1: After reset the ranking is way i in slot i: slot 0 (the oldest) holds way 0 and the last slot (the newest) holds way NUM_WAYS-1. The eviction candidate is therefore way 0.
- R2: A lookup strobe with the hit flag set moves the reported way to the newest slot. The ways that stood after it each move one slot toward the oldest end, and the ways before it keep their slots.
- R3: A fill strobe moves the filled way to the newest slot, in the same shifting manner as R2.
- R4: A lookup strobe with the hit flag clear, and no fill in the same cycle, leaves the ranking unchanged.
- R5: When the lookup strobe is low, the hit flag and way inputs are ignored. With no fill either, the ranking holds.
- R6: The eviction candidate always equals the way in the oldest slot, with no register in between. A strobe changes it only from the next rising clock edge onward.
- R7: When a hit and a fill arrive in the same cycle, the hit is applied first and the fill second. The filled way ends newest, and the hit way (if different) ends second newest.
- R8: Touching the way that is already newest leaves the ranking unchanged.
- R9: The ranking is always a permutation of the ways: every way appears in exactly one slot.
- R10: Four ways hold blocks 0, 4, 8 and 12 on ways 0 to 3, with block 0 oldest. The accesses 4, 16, 12, 0, 4 then give: hit, miss evicting block 0, hit, miss evicting block 8, hit. The final ranking from oldest to newest is blocks 16, 12, 0, 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Lookup strobe |
| acc_hit | input | 1 | The lookup hit |
| acc_way | input | WAY_W | Way that hit |
| fill_valid | input | 1 | Fill strobe |
| fill_way | input | WAY_W | Way written by the fill |
| victim_way | output | WAY_W | Least recently used way (eviction candidate) |
| recency_list | output | NUM_WAYS*WAY_W | Ranking; slot s at bits [s*WAY_W +: WAY_W], slot 0 oldest |

## Verification
The bench sweeps every combination of lookup strobe, hit flag, hit way, fill strobe and fill way, over several passes that start from different rankings. Each result is compared against a list model that removes the way and appends it.

Several corner cases are targeted directly:
- Touching the newest way, which a design with an off-by-one shift would corrupt.
- Simultaneous hit and fill, where the wrong priority would leave the hit way newest.
- Misses or idle cycles that must not move anything, where a design decoding the way without the strobe would drift.

The eviction candidate is also sampled before the clock edge. A registered victim path would show a stale value there, and a combinational update path would show an early one.

// File: rtl/lru_pkg.sv
package lru_pkg;
    // Bits needed to encode a way number; at least one.
    function automatic int way_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/lru_promote.sv
// Moves one way to the newest slot of a ranking; slot 0 is oldest.
module lru_promote #(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = 2
) (
    input  logic                      en,
    input  logic [WAY_W-1:0]          way,
    input  logic [NUM_WAYS*WAY_W-1:0] order_in,
    output logic [NUM_WAYS*WAY_W-1:0] order_out
);
    logic [NUM_WAYS-1:0] match;
    logic [NUM_WAYS-1:0] at_or_after;

    generate
        for (genvar s = 0; s < NUM_WAYS; s++) begin : g_match
            assign match[s] = (order_in[s*WAY_W +: WAY_W] == way);
        end
    endgenerate

    // Prefix OR: slot s is at or beyond the matching slot.
    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int s = 0; s < NUM_WAYS; s++) begin
            seen           = seen | match[s];
            at_or_after[s] = seen;
        end
    end

    generate
        for (genvar s = 0; s < NUM_WAYS; s++) begin : g_shift
            if (s == NUM_WAYS - 1) begin : g_top
                assign order_out[s*WAY_W +: WAY_W] =
                    (en && at_or_after[s]) ? way : order_in[s*WAY_W +: WAY_W];
            end else begin : g_mid
                assign order_out[s*WAY_W +: WAY_W] =
                    (en && at_or_after[s]) ? order_in[(s+1)*WAY_W +: WAY_W]
                                           : order_in[s*WAY_W +: WAY_W];
            end
        end
    endgenerate
endmodule

// File: rtl/lru_ends.sv
// Taps the oldest and newest slots of a ranking.
module lru_ends #(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = 2
) (
    input  logic [NUM_WAYS*WAY_W-1:0] order,
    output logic [WAY_W-1:0]          oldest,
    output logic [WAY_W-1:0]          newest
);
    assign oldest = order[0 +: WAY_W];
    assign newest = order[(NUM_WAYS-1)*WAY_W +: WAY_W];
endmodule

// File: rtl/lru_tracker.sv
module lru_tracker
    import lru_pkg::*;
#(
    parameter int  NUM_WAYS = 4,
    localparam int WAY_W    = way_bits(NUM_WAYS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_valid,
    input  logic                      acc_hit,
    input  logic [WAY_W-1:0]          acc_way,
    input  logic                      fill_valid,
    input  logic [WAY_W-1:0]          fill_way,
    output logic [WAY_W-1:0]          victim_way,
    output logic [NUM_WAYS*WAY_W-1:0] recency_list
);
    localparam int LIST_W = NUM_WAYS * WAY_W;

    typedef struct packed {
        logic [LIST_W-1:0] order;
    } state_t;

    state_t            st_d, st_q;
    logic [LIST_W-1:0] init_order;
    logic [LIST_W-1:0] after_hit_d;
    logic [LIST_W-1:0] after_fill_d;
    logic              hit_en;
    logic [WAY_W-1:0]  newest_w;

    // R1: reset ranking is the identity, so empty ways go out in ascending order.
    generate
        for (genvar s = 0; s < NUM_WAYS; s++) begin : g_init
            assign init_order[s*WAY_W +: WAY_W] = WAY_W'(s);
        end
    endgenerate

    assign hit_en = acc_valid & acc_hit;

    // R7: the hit stage feeds the fill stage, so the fill wins the newest slot.
    lru_promote #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_hit_stage (
        .en        (hit_en),
        .way       (acc_way),
        .order_in  (st_q.order),
        .order_out (after_hit_d)
    );

    lru_promote #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_fill_stage (
        .en        (fill_valid),
        .way       (fill_way),
        .order_in  (after_hit_d),
        .order_out (after_fill_d)
    );

    always_comb begin
        st_d       = st_q;
        st_d.order = after_fill_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.order <= init_order;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: victim comes straight from the oldest slot.
    lru_ends #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_ends (
        .order  (st_q.order),
        .oldest (victim_way),
        .newest (newest_w)
    );

    assign recency_list = st_q.order;

    // Presence of each way in the ranking, for the permutation check.
    logic [NUM_WAYS-1:0] present;
    always_comb begin
        present = '0;
        for (int s = 0; s < NUM_WAYS; s++) begin
            if (int'(st_q.order[s*WAY_W +: WAY_W]) < NUM_WAYS) begin
                present[st_q.order[s*WAY_W +: WAY_W]] = 1'b1;
            end
        end
    end

    a_r9_permutation: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(present) == NUM_WAYS);

    a_r2_hit_newest: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_en && !fill_valid) |=> (newest_w == $past(acc_way)));

    a_r3_fill_newest: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (newest_w == $past(fill_way)));

    a_r4_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit && !fill_valid) |=> $stable(recency_list));

    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !fill_valid) |=> $stable(recency_list));

    a_r7_hit_second: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_en && fill_valid && (acc_way != fill_way)) |=>
            (recency_list[(NUM_WAYS-2)*WAY_W +: WAY_W] == $past(acc_way)));

    a_r8_newest_touch: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_en && !fill_valid && (acc_way == newest_w)) |=> $stable(recency_list));
endmodule

// File: tb/lru_tracker_bench.sv
`timescale 1ns/1ps
module lru_tracker_bench;
    localparam int N = 4;
    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         acc_valid = 1'b0, acc_hit = 1'b0, fill_valid = 1'b0;
    logic [W-1:0] acc_way = '0, fill_way = '0;
    logic [W-1:0] victim_way;
    logic [N*W-1:0] recency_list;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int model[$];

    always #2.5 clk = ~clk;

    lru_tracker #(.NUM_WAYS(N)) u_lru_tracker (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
        .acc_way(acc_way), .fill_valid(fill_valid), .fill_way(fill_way),
        .victim_way(victim_way), .recency_list(recency_list)
    );

    task automatic summary_and_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog: actual cycles=%0d expected <= 100000", cycles);
            summary_and_end();
        end
    end

    function automatic logic [N*W-1:0] pack_model();
        logic [N*W-1:0] v = '0;
        for (int s = 0; s < N; s++) v[s*W +: W] = W'(model[s]);
        return v;
    endfunction

    function automatic void model_touch(input int w);
        for (int s = 0; s < model.size(); s++) begin
            if (model[s] == w) begin
                model.delete(s);
                break;
            end
        end
        model.push_back(w);
    endfunction

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        check_eq(req, 32'(recency_list), 32'(pack_model()));
        check_eq({req, " R6 victim"}, 32'(victim_way), 32'(model[0]));
    endtask

    // One cycle of stimulus, driven on the falling edge.
    task automatic step(input logic av, input logic h, input int aw,
                        input logic fv, input int fw, input string req);
        @(negedge clk);
        acc_valid = av; acc_hit = h; acc_way = W'(aw);
        fill_valid = fv; fill_way = W'(fw);
        #1;
        // R6: nothing moves before the edge.
        check_eq("R6 pre-edge victim", 32'(victim_way), 32'(model[0]));
        if (av && h) model_touch(aw);
        if (fv) model_touch(fw);
        @(posedge clk);
        #1;
        acc_valid = 1'b0; fill_valid = 1'b0;
        check_state(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        model.delete();
        for (int s = 0; s < N; s++) model.push_back(s);
    endtask

    initial begin
        do_reset();
        // R1: identity ranking after reset
        check_eq("R1 reset list", 32'(recency_list), 32'h0000_00E4);
        check_eq("R1 reset victim", 32'(victim_way), 32'd0);

        // R5: strobe low, hit flag and way ignored
        step(1'b0, 1'b1, 2, 1'b0, 0, "R5 idle");
        // R4: miss without fill holds
        step(1'b1, 1'b0, 3, 1'b0, 0, "R4 miss");
        // R8: touching newest way
        step(1'b1, 1'b1, 3, 1'b0, 0, "R8 newest hit");
        // R2 / R3 basic
        step(1'b1, 1'b1, 0, 1'b0, 0, "R2 hit oldest");
        step(1'b0, 1'b0, 0, 1'b1, 2, "R3 fill middle");
        // R7 simultaneous
        step(1'b1, 1'b1, 1, 1'b1, 3, "R7 hit+fill");
        check_eq("R7 second newest", 32'(recency_list[(N-2)*W +: W]), 32'd1);

        // Exhaustive sweep over all strobe/way combinations, several passes (R2 R3 R4 R5 R7 R8 R9)
        for (int pass = 0; pass < 3; pass++) begin
            for (int av = 0; av < 2; av++)
                for (int h = 0; h < 2; h++)
                    for (int aw = 0; aw < N; aw++)
                        for (int fv = 0; fv < 2; fv++)
                            for (int fw = 0; fw < N; fw++)
                                step(av[0], h[0], (aw + pass) % N, fv[0], (fw + 2*pass) % N,
                                     "R2/R3/R4/R5/R7 sweep");
        end

        // R10: worked example, blocks 0,4,8,12 on ways 0..3
        do_reset();
        for (int w = 0; w < N; w++) step(1'b0, 1'b0, 0, 1'b1, w, "R10 preload");
        step(1'b1, 1'b1, 1, 1'b0, 0, "R10 access 4 hit");
        check_eq("R10 victim before 16", 32'(victim_way), 32'd0);   // block 0 evicted
        step(1'b1, 1'b0, 0, 1'b0, 0, "R10 access 16 miss");
        step(1'b0, 1'b0, 0, 1'b1, 0, "R10 fill 16");
        step(1'b1, 1'b1, 3, 1'b0, 0, "R10 access 12 hit");
        check_eq("R10 victim before 0", 32'(victim_way), 32'd2);    // block 8 evicted
        step(1'b1, 1'b0, 0, 1'b0, 0, "R10 access 0 miss");
        step(1'b0, 1'b0, 0, 1'b1, 2, "R10 fill 0");
        step(1'b1, 1'b1, 1, 1'b0, 0, "R10 access 4 hit");
        // oldest..newest blocks 16,12,0,4 -> ways 0,3,2,1
        check_eq("R10 final list", 32'(recency_list), 32'h0000_006C);

        summary_and_end();
    end
endmodule